// File: doc/BRIEF.md
# Up/Down Counter with Dual Compare-Match Interrupts

This block holds a 16-bit counter and two 16-bit compare registers. While the counter is enabled, each compare register is checked against the counter value on every clock. The first cycle of equality raises a one-clock interrupt pulse on that channel's own output.

A two-bit mode input selects how the counter moves and which matches count as interrupts:
- In timer mode the counter only counts up.
- In both up/down variants, a direction input sets the step direction.
- Variant B accepts a match only when the most recent count step went down.

A small word-wide register port writes the compare registers and reads them and the counter. Compare writes are refused while the counter is enabled. A one-cycle flag reports each refused write.

Top module: `updn_cmp_unit`

## Requirements
- R1: After reset the counter and both compare registers read 0x0000, both interrupt outputs are low and the write-rejected flag is low.
- R2: In timer mode (mode = 00), each clock with counter enable and step both high adds one to the counter, whatever the direction input is.
- R3: In up/down modes (mode = 01 variant A; mode = 10 or 11 variant B), each enabled step subtracts one when dir_down is 1 and adds one otherwise, wrapping modulo 2^16 (0x0000 down gives 0xFFFF, 0xFFFF up gives 0x0000).
- R4: While counter enable is low, the counter holds its value and neither interrupt output is asserted, even if a compare register equals the counter.
- R5: In timer mode and variant A, an interrupt pulse is asserted combinationally in the first enabled cycle in which a channel's compare register equals the counter. It lasts one cycle and does not repeat while the equality persists.
- R6: In variant B, a channel's interrupt is asserted only if its first cycle of equality falls while the most recent count step was downward. A step in timer mode counts as upward, and the direction is upward after reset. Equalities reached while counting up raise nothing.
- R7: A write to a compare register while counter enable is high is discarded: the register keeps its value, and wr_reject is high for exactly the following cycle.
- R8: Register port: bus_addr 0 selects compare channel 0 and bus_addr 1 selects compare channel 1. Both are written whole-word on bus_wr when the counter is disabled, and the new value is visible from the next cycle. Address 2 reads the counter, and writes to it are ignored. Address 3 reads 0x0000. Reads are combinational.
- R9: The two channels are independent: each channel's interrupt depends only on its own compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable; also gates match detection and locks compare writes |
| mode | input | 2 | 00 timer, 01 up/down variant A, 1x up/down variant B |
| dir_down | input | 1 | Count direction in up/down modes (1 = down) |
| step | input | 1 | Count strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| count | output | 16 | Current counter value |
| irq | output | 2 | Per-channel match interrupt pulses |
| wr_reject | output | 1 | One-cycle flag for a discarded compare write |

## Verification
A compare write attempt and a compare match can fall in the same cycle. The bench arranges this by stepping the counter onto a compare value and issuing a write to that same register in the cycle where equality first appears. The interrupt must follow the old register value, the write must be refused with wr_reject on the next cycle, and the read-back must still show the old value. Random phases repeat this collision, and collisions of a count step with a direction reversal in variant B, while a behavioural model is compared on every clock.

// File: rtl/updn_cmp_unit.sv
module updn_cmp_unit #(
  parameter int W   = 16,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_en,
  input  logic [1:0]     mode,
  input  logic           dir_down,
  input  logic           step,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  output logic [W-1:0]   count,
  output logic [NCH-1:0] irq,
  output logic           wr_reject
);

  localparam logic [1:0] CNT_ADDR = 2'(NCH);

  logic [W-1:0]            cnt_q;
  logic [NCH-1:0][W-1:0]   cmp_q;
  logic [NCH-1:0]          seen_q;
  logic [NCH-1:0]          match;
  logic                    down_q;
  logic                    rej_q;

  wire updn   = mode != 2'b00;
  wire only_dn = mode[1];
  wire cmp_sel = bus_addr < CNT_ADDR;
  wire wr_cmp  = bus_wr && cmp_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (cnt_en && step) begin
      if (updn) begin
        cnt_q  <= dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
        down_q <= dir_down;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        down_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rej_q <= 1'b0;
    else        rej_q <= wr_cmp && cnt_en;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_q[ch]  <= '0;
        seen_q[ch] <= 1'b0;
      end else begin
        seen_q[ch] <= match[ch];
        if (wr_cmp && !cnt_en && bus_addr == 2'(ch)) cmp_q[ch] <= bus_wdata;
      end
    end

    assign match[ch] = cnt_en && (cnt_q == cmp_q[ch]);
    assign irq[ch]   = match[ch] && !seen_q[ch] && (!only_dn || down_q);

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq[ch] |=> !irq[ch]);
    a_r4_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |-> !irq[ch]);
    a_r7_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && cnt_en && bus_addr == 2'(ch)) |=> $stable(cmp_q[ch]));
    a_r6_no_up_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (only_dn && cnt_en && step && !dir_down) |=> (!mode[1] || !irq[ch]));
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == 2'(i)) bus_rdata = cmp_q[i];
    if (bus_addr == CNT_ADDR) bus_rdata = cnt_q;
  end

  assign count     = cnt_q;
  assign wr_reject = rej_q;

  a_r7_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && cnt_en && cmp_sel) |=> wr_reject);
  a_r3_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && step && updn && dir_down && count == '0) |=> count == {W{1'b1}});
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

endmodule

// File: tb/updn_cmp_unit_test.sv
module updn_cmp_unit_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, cnt_en = 1'b0, dir_down = 1'b0, step = 1'b0, bus_wr = 1'b0;
  logic [1:0]  mode = 2'b00, bus_addr = 2'b00;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, count;
  logic [1:0]  irq;
  logic        wr_reject;

  updn_cmp_unit uut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
    .dir_down(dir_down), .step(step), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count), .irq(irq),
    .wr_reject(wr_reject));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int m_cnt = 0;
  int m_c[2] = '{0, 0};
  bit m_seen[2] = '{0, 0};
  bit m_down = 0, m_rej = 0;
  int pulses[2] = '{0, 0};

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit en, logic [1:0] md, bit dn, bit st, bit wr, logic [1:0] ad, int wd);
    bit mt[2];
    bit ei;
    int er;
    cnt_en = en; mode = md; dir_down = dn; step = st;
    bus_wr = wr; bus_addr = ad; bus_wdata = 16'(wd);
    #1;
    for (int i = 0; i < 2; i++) begin
      mt[i] = en && (m_cnt == m_c[i]);
      ei = mt[i] && !m_seen[i] && (!md[1] || m_down);
      chk(irq[i] == ei, md[1] ? "R6" : "R5", $sformatf("irq%0d", i), irq[i], ei);
      if (irq[i]) pulses[i]++;
    end
    er = (ad == 0) ? m_c[0] : (ad == 1) ? m_c[1] : (ad == 2) ? m_cnt : 0;
    chk(bus_rdata == 16'(er), "R8", "rdata", bus_rdata, er);
    chk(count == 16'(m_cnt), md == 0 ? "R2" : "R3", "count", count, m_cnt);
    chk(wr_reject == m_rej, "R7", "wr_reject", wr_reject, m_rej);
    if (en && st) begin
      if (md != 0) begin
        m_cnt = dn ? (m_cnt - 1) & 16'hFFFF : (m_cnt + 1) & 16'hFFFF;
        m_down = dn;
      end else begin
        m_cnt = (m_cnt + 1) & 16'hFFFF;
        m_down = 0;
      end
    end
    for (int i = 0; i < 2; i++) m_seen[i] = mt[i];
    m_rej = wr && en && (ad < 2);
    if (wr && !en && ad < 2) m_c[ad] = wd & 16'hFFFF;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0, p1;
    repeat (3) @(negedge clk);
    #1;
    chk(count == 0 && irq == 0 && wr_reject == 0 && bus_rdata == 0, "R1", "reset state",
        {count, 2'b0, irq, wr_reject}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 0, 0, 1, 1, 1); // R1 read cmp1 still zero while writing
    // R8 writes while disabled
    cyc(0, 0, 0, 0, 1, 0, 5);
    cyc(0, 0, 0, 0, 1, 1, 3);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk(bus_rdata == 16'd5, "R8", "cmp0 readback", bus_rdata, 5);
    cyc(0, 0, 0, 0, 0, 1, 0);
    // R2 timer mode ignores direction; R9 independent channels
    p0 = pulses[0]; p1 = pulses[1];
    for (int k = 0; k < 8; k++) cyc(1, 2'b00, k[0], 1, 0, 2, 0);
    cyc(1, 2'b00, 0, 0, 0, 2, 0);
    chk(count == 16'd8, "R2", "count after 8 steps", count, 8);
    chk(pulses[0] - p0 == 1 && pulses[1] - p1 == 1, "R9", "pulses per channel",
        (pulses[0] - p0) * 16 + pulses[1] - p1, 17);
    // R5 hold on a match, collide with a write attempt (R7)
    cyc(0, 0, 0, 0, 1, 0, 10);
    p0 = pulses[0];
    cyc(1, 2'b01, 0, 1, 0, 0, 0);
    cyc(1, 2'b01, 0, 1, 0, 0, 0);
    cyc(1, 2'b01, 0, 0, 1, 0, 16'h1234);
    cyc(1, 2'b01, 0, 0, 0, 0, 0);
    cyc(1, 2'b01, 0, 0, 0, 0, 0);
    chk(pulses[0] - p0 == 1, "R5", "single pulse on held match", pulses[0] - p0, 1);
    chk(bus_rdata == 16'd10, "R7", "cmp0 kept", bus_rdata, 10);
    // R4 disabled while equal, write to counter address ignored
    p0 = pulses[0];
    cyc(0, 2'b01, 0, 1, 1, 2, 16'hBEEF);
    cyc(0, 2'b01, 0, 1, 0, 2, 0);
    chk(bus_rdata == 16'd10, "R4", "counter held and write ignored", bus_rdata, 10);
    chk(pulses[0] == p0, "R4", "no irq while disabled", pulses[0] - p0, 0);
    cyc(0, 2'b01, 0, 0, 0, 3, 0);
    chk(bus_rdata == 16'd0, "R8", "address 3 reads zero", bus_rdata, 0);
    // R3 variant A downward with wrap
    cyc(0, 0, 0, 0, 1, 0, 2);
    cyc(0, 0, 0, 0, 1, 1, 16'hFFFE);
    p0 = pulses[0]; p1 = pulses[1];
    for (int k = 0; k < 12; k++) cyc(1, 2'b01, 1, 1, 0, 2, 0);
    cyc(1, 2'b01, 1, 0, 0, 2, 0);
    chk(count == 16'hFFFE, "R3", "wrap below zero", count, 16'hFFFE);
    chk(pulses[0] - p0 == 1 && pulses[1] - p1 == 1, "R3", "pulses across wrap",
        (pulses[0] - p0) * 16 + pulses[1] - p1, 17);
    // R6 variant B: up through match silent, down onto it fires
    cyc(0, 0, 0, 0, 1, 0, 5);
    cyc(0, 0, 0, 0, 1, 1, 16'h0100);
    p0 = pulses[0];
    for (int k = 0; k < 8; k++) cyc(1, 2'b10, 0, 1, 0, 2, 0);
    cyc(1, 2'b10, 0, 0, 0, 2, 0);
    chk(pulses[0] == p0, "R6", "no irq counting up", pulses[0] - p0, 0);
    cyc(1, 2'b10, 1, 1, 0, 2, 0);
    cyc(1, 2'b10, 1, 0, 0, 2, 0);
    chk(pulses[0] - p0 == 1, "R6", "irq counting down", pulses[0] - p0, 1);
    // random phase with compare values near the count
    for (int k = 0; k < 4000; k++) begin
      bit en, wr;
      en = ($urandom % 8) != 0;
      wr = ($urandom % 5) == 0;
      cyc(en, 2'($urandom), 1'($urandom), ($urandom % 3) != 0, wr, 2'($urandom),
          (m_cnt + int'($urandom % 7) - 3) & 16'hFFFF);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule